// File: doc/BRIEF.md
# Stopwatch Core with Lap Hold

This block is the timing heart of a hand-held stopwatch. It divides the system clock down to a count step. It keeps the elapsed time as a chain of decimal digits: minutes, seconds and hundredths of a second. Six held digits go out to a display stage.

Two command inputs steer it. Both are single-cycle pulses that arrive already debounced. One is a start/stop toggle and the other is a lap/clear command. A four-state mode machine decides what each pulse means. Its three-bit state code is used directly as the control word: one bit clears the time, one bit lets it count, and one bit opens the display register.

The lap mode freezes the displayed value while the time keeps counting underneath. A second lap pulse makes the display catch up with the live count.

Top module: `stopwatch_core`

## Requirements
- R1: The displayed time spans 00:00:00 to 59:59:99 (minutes, seconds, hundredths) with the default minute-tens limit of 5. One step past the maximum returns every digit to zero.
- R2: Digit radices follow these rules:
  - The seconds-tens digit returns to 0 after 5.
  - The minutes-tens digit returns to 0 after MIN_TENS_MAX.
  - Every other digit returns to 0 after 9.
  - The hundredths digit advances once per DIV_CYCLES*SUB_TICKS counting cycles (defaults 48000 and 10, i.e. 1 ms ticks from 48 MHz and ten ticks per hundredth).
  - Both prescaler stages restart from zero whenever the time is cleared.
- R3: A synchronous active-high `rst` puts the block in the clear mode and sets every digit to zero.
- R4: The mode codes are as follows:
  - clear is 111, run is 011, hold is 001 and lap is 010.
  - Bit 2 clears the time, bit 1 lets it count, and bit 0 loads the display register every cycle.
  - Any other code moves to clear.
  - The display therefore shows the live time one clock cycle late whenever bit 0 is set.
- R5: In clear, a start/stop pulse moves to run; a lap/clear pulse has no effect.
- R6: In run, a start/stop pulse moves to hold. In hold, the time does not advance and the display shows it. A further start/stop pulse resumes counting from the held value. The edge that samples a command still acts in the old mode.
- R7: In run, a lap/clear pulse moves to lap. In lap, the display stays frozen while the time keeps counting. A second lap/clear pulse returns to run and the display shows the live time again.
- R8: In hold, a lap/clear pulse moves to clear and all digits become zero.
- R9: In lap, a start/stop pulse has no effect.
- R10: When both pulses are high in the same cycle, the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start/stop pulse, one cycle wide |
| cmd_lap | input | 1 | Lap/clear pulse, one cycle wide |
| disp_min_tens | output | 4 | Held minutes tens digit, BCD |
| disp_min_units | output | 4 | Held minutes units digit, BCD |
| disp_sec_tens | output | 4 | Held seconds tens digit, BCD |
| disp_sec_units | output | 4 | Held seconds units digit, BCD |
| disp_cs_tens | output | 4 | Held hundredths tens digit, BCD |
| disp_cs_units | output | 4 | Held hundredths units digit, BCD |

## Verification
Two things can land in the same cycle.

- **Both command pulses together.** The bench raises start/stop and lap/clear together in the clear, run and hold modes. It judges the result by what follows: the count stays zero, keeps running to the exact expected total, or stays frozen.
- **A command sampled on the same edge as a count step.** The bench runs with a prescaler of one, so every run edge is a count step. The expected totals count the command edge in the old mode. A third instance with a 3x2 prescaler checks that the divider phase restarts on clear.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int NDIG       = 6;
    localparam int DIGIT_W    = 4;
    localparam int TIME_W     = NDIG * DIGIT_W;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // State code doubles as the control word {clear, count, load}
    typedef enum logic [2:0] {
        MODE_CLEAR = 3'b111,
        MODE_RUN   = 3'b011,
        MODE_HOLD  = 3'b001,
        MODE_LAP   = 3'b010
    } mode_e;

    typedef struct packed {
        logic clr;
        logic cnt_en;
        logic ld_en;
    } ctrl_t;

    // Most significant digit first so that slice 4*i picks digit i
    typedef struct packed {
        bcd_t min_t;
        bcd_t min_u;
        bcd_t sec_t;
        bcd_t sec_u;
        bcd_t cs_t;
        bcd_t cs_u;
    } sw_time_t;

    // Highest value of digit idx (0 = hundredths units ... 5 = minutes tens)
    function automatic bcd_t digit_max(input int idx, input int min_tens_max);
        case (idx)
            3:       return bcd_t'(5);
            5:       return bcd_t'(min_tens_max);
            default: return bcd_t'(9);
        endcase
    endfunction

    function automatic ctrl_t mode_ctrl(input logic [2:0] code);
        return ctrl_t'(code);
    endfunction

endpackage

// File: rtl/sw_prescale.sv
module sw_prescale #(
    parameter int DIV_CYCLES = 48000,
    parameter int SUB_TICKS  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic step_o
);
    logic tick;

    generate
        if (DIV_CYCLES > 1) begin : g_div
            localparam int W = $clog2(DIV_CYCLES);
            localparam logic [W-1:0] LAST = W'(DIV_CYCLES - 1);
            logic [W-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    div_q <= '0;
                else if (en)
                    div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
            end
            assign tick = en && (div_q == LAST);
        end else begin : g_nodiv
            assign tick = en;
        end
    endgenerate

    generate
        if (SUB_TICKS > 1) begin : g_sub
            localparam int W = $clog2(SUB_TICKS);
            localparam logic [W-1:0] LAST = W'(SUB_TICKS - 1);
            logic [W-1:0] sub_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    sub_q <= '0;
                else if (tick)
                    sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
            end
            assign step_o = tick && (sub_q == LAST);
        end else begin : g_nosub
            assign step_o = tick;
        end
    endgenerate

endmodule

// File: rtl/sw_bcd_chain.sv
module sw_bcd_chain
    import sw_pkg::*;
#(
    parameter int MIN_TENS_MAX = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     step,
    output sw_time_t value_o
);
    logic [NDIG-1:0]   carry;
    logic [TIME_W-1:0] flat;

    assign carry[0] = step;

    generate
        for (genvar i = 0; i < NDIG; i++) begin : g_dig
            localparam bcd_t LIM = digit_max(i, MIN_TENS_MAX);
            bcd_t d_q;
            always_ff @(posedge clk) begin
                if (rst || clr)
                    d_q <= '0;
                else if (carry[i])
                    d_q <= (d_q == LIM) ? '0 : d_q + 1'b1;
            end
            assign flat[DIGIT_W*i +: DIGIT_W] = d_q;
            if (i < NDIG - 1) begin : g_carry
                assign carry[i+1] = carry[i] && (d_q == LIM);
            end
        end
    endgenerate

    assign value_o = sw_time_t'(flat);

endmodule

// File: rtl/sw_mode_fsm.sv
module sw_mode_fsm
    import sw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic       lap_i,
    output logic [2:0] code_o
);
    logic [2:0] code_q;
    logic [2:0] code_d;
    logic       only_go;
    logic       only_lap;

    assign only_go  = go_i && !lap_i;
    assign only_lap = lap_i && !go_i;

    always_comb begin
        code_d = code_q;
        case (code_q)
            MODE_CLEAR: if (only_go) code_d = MODE_RUN;
            MODE_RUN: begin
                if (only_go)       code_d = MODE_HOLD;
                else if (only_lap) code_d = MODE_LAP;
            end
            MODE_HOLD: begin
                if (only_lap)      code_d = MODE_CLEAR;
                else if (only_go)  code_d = MODE_RUN;
            end
            MODE_LAP:   if (only_lap) code_d = MODE_RUN;
            default:    code_d = MODE_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= MODE_CLEAR;
        else
            code_q <= code_d;
    end

    assign code_o = code_q;

endmodule

// File: rtl/sw_hold_reg.sv
module sw_hold_reg
    import sw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ld,
    input  sw_time_t d_i,
    output sw_time_t q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (ld)
            q_o <= d_i;
    end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
    import sw_pkg::*;
#(
    parameter int DIV_CYCLES   = 48000,
    parameter int SUB_TICKS    = 10,
    parameter int MIN_TENS_MAX = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_go,
    input  logic       cmd_lap,
    output logic [3:0] disp_min_tens,
    output logic [3:0] disp_min_units,
    output logic [3:0] disp_sec_tens,
    output logic [3:0] disp_sec_units,
    output logic [3:0] disp_cs_tens,
    output logic [3:0] disp_cs_units
);
    logic [2:0]        mode_q;
    ctrl_t             ctl;
    logic              step;
    sw_time_t          live;
    sw_time_t          shown;
    logic [TIME_W-1:0] live_flat;
    logic [TIME_W-1:0] shown_flat;

    sw_mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .go_i   (cmd_go),
        .lap_i  (cmd_lap),
        .code_o (mode_q)
    );

    assign ctl = mode_ctrl(mode_q);

    sw_prescale #(
        .DIV_CYCLES (DIV_CYCLES),
        .SUB_TICKS  (SUB_TICKS)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl.clr),
        .en     (ctl.cnt_en),
        .step_o (step)
    );

    sw_bcd_chain #(
        .MIN_TENS_MAX (MIN_TENS_MAX)
    ) u_chain (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr),
        .step    (step),
        .value_o (live)
    );

    sw_hold_reg u_hold (
        .clk (clk),
        .rst (rst),
        .ld  (ctl.ld_en),
        .d_i (live),
        .q_o (shown)
    );

    assign live_flat      = live;
    assign shown_flat     = shown;
    assign disp_min_tens  = shown.min_t;
    assign disp_min_units = shown.min_u;
    assign disp_sec_tens  = shown.sec_t;
    assign disp_sec_units = shown.sec_u;
    assign disp_cs_tens   = shown.cs_t;
    assign disp_cs_units  = shown.cs_u;

endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
    parameter int MIN_TENS_MAX = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        go,
    input logic        lap,
    input logic [2:0]  mode,
    input logic [23:0] live,
    input logic [23:0] shown
);
    // R4: only the four legal codes are ever held
    a_r4_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode inside {3'b111, 3'b011, 3'b001, 3'b010});

    // R5: start from clear
    a_r5_clear_to_run: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b111 && go && !lap) |=> (mode == 3'b011));

    // R6: hold freezes the live time
    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b001) |=> $stable(live));

    // R7: lap freezes the display
    a_r7_lap_display_frozen: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b010) |=> $stable(shown));

    // R8: lap/clear in hold goes to clear, and clear zeroes the time
    a_r8_hold_to_clear: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b001 && lap && !go) |=> (mode == 3'b111));
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b111) |=> (live == 24'h0));

    // R9: start/stop ignored in lap
    a_r9_lap_ignores_go: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b010 && go && !lap) |=> (mode == 3'b010));

    // R10: simultaneous commands leave the mode alone
    a_r10_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (go && lap) |=> $stable(mode));

    // R2: every shown digit within its radix
    a_r2_digit_range: assert property (@(posedge clk) disable iff (rst)
        (shown[3:0] <= 4'd9) && (shown[7:4] <= 4'd9) &&
        (shown[11:8] <= 4'd9) && (shown[15:12] <= 4'd5) &&
        (shown[19:16] <= 4'd9) && (shown[23:20] <= 4'(MIN_TENS_MAX)));

endmodule

bind stopwatch_core sw_checker #(
    .MIN_TENS_MAX (MIN_TENS_MAX)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .go    (cmd_go),
    .lap   (cmd_lap),
    .mode  (mode_q),
    .live  (live_flat),
    .shown (shown_flat)
);

// File: tb/stopwatch_core_tb_top.sv
module stopwatch_core_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic lap = 1'b0;
    int   cyc = 0;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic [3:0] i_mt, i_mu, i_st, i_su, i_ct, i_cu;
    logic [3:0] w_mt, w_mu, w_st, w_su, w_ct, w_cu;
    logic [3:0] d_mt, d_mu, d_st, d_su, d_ct, d_cu;

    stopwatch_core #(.DIV_CYCLES(1), .SUB_TICKS(1), .MIN_TENS_MAX(5)) dut_i (
        .clk(clk), .rst(rst), .cmd_go(go), .cmd_lap(lap),
        .disp_min_tens(i_mt), .disp_min_units(i_mu), .disp_sec_tens(i_st),
        .disp_sec_units(i_su), .disp_cs_tens(i_ct), .disp_cs_units(i_cu));

    stopwatch_core #(.DIV_CYCLES(1), .SUB_TICKS(1), .MIN_TENS_MAX(0)) dut_w (
        .clk(clk), .rst(rst), .cmd_go(go), .cmd_lap(lap),
        .disp_min_tens(w_mt), .disp_min_units(w_mu), .disp_sec_tens(w_st),
        .disp_sec_units(w_su), .disp_cs_tens(w_ct), .disp_cs_units(w_cu));

    stopwatch_core #(.DIV_CYCLES(3), .SUB_TICKS(2), .MIN_TENS_MAX(5)) dut_d (
        .clk(clk), .rst(rst), .cmd_go(go), .cmd_lap(lap),
        .disp_min_tens(d_mt), .disp_min_units(d_mu), .disp_sec_tens(d_st),
        .disp_sec_units(d_su), .disp_cs_tens(d_ct), .disp_cs_units(d_cu));

    wire [23:0] sh_i = {i_mt, i_mu, i_st, i_su, i_ct, i_cu};
    wire [23:0] sh_w = {w_mt, w_mu, w_st, w_su, w_ct, w_cu};
    wire [23:0] sh_d = {d_mt, d_mu, d_st, d_su, d_ct, d_cu};

    function automatic logic [23:0] exp_bcd(input int n, input int mt);
        int h = n % 100;
        int s = (n / 100) % 60;
        int m = (n / 6000) % (10 * (mt + 1));
        return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10), 4'(h / 10), 4'(h % 10)};
    endfunction

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // n counting edges so far; the 3x2 prescaled instance shows n/6
    task automatic chk3(input string req, input int n);
        chk({req, " base"},  sh_i, exp_bcd(n, 5));
        chk({req, " wrap"},  sh_w, exp_bcd(n, 0));
        chk({req, " presc"}, sh_d, exp_bcd(n / 6, 5));
    endtask

    // Called at a negedge; the pulse is sampled on the next posedge,
    // whose index is returned. Ends at the following negedge.
    task automatic send(input logic g, input logic l, output int at);
        go  = g;
        lap = l;
        @(posedge clk);
        #1 at = cyc;
        @(negedge clk);
        go  = 1'b0;
        lap = 1'b0;
    endtask

    // Wait at negedges until the next sampled edge would be E+T
    task automatic run_until(input int e, input int t);
        while (cyc < e + t - 1) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        int e;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk3("R3 reset zero", 0);
        send(1'b0, 1'b1, e);
        idle(5);
        chk3("R5 lap ignored in clear", 0);
        send(1'b1, 1'b1, e);
        idle(5);
        chk3("R10 both ignored in clear", 0);
    endtask

    task automatic t_pause_resume;
        int e, p, n, x;
        send(1'b1, 1'b0, e);
        run_until(e, 37);
        send(1'b1, 1'b0, p);
        n = p - e;
        idle(1);
        chk3("R6 hold value", n);
        idle(50);
        chk3("R6 hold stays", n);
        send(1'b1, 1'b1, x);
        idle(10);
        chk3("R10 both ignored in hold", n);
        send(1'b1, 1'b0, e);
        run_until(e, 20);
        send(1'b1, 1'b0, p);
        n = n + (p - e);
        idle(1);
        chk3("R6 resume from held", n);
    endtask

    task automatic t_clear;
        int e;
        send(1'b0, 1'b1, e);
        idle(3);
        chk3("R8 hold lap clears", 0);
    endtask

    task automatic t_split;
        int e, s, x, u, p;
        send(1'b1, 1'b0, e);
        run_until(e, 150);
        send(1'b0, 1'b1, s);
        chk3("R7 lap freezes", s - 1 - e);
        idle(220);
        chk3("R7 frozen across seconds", s - 1 - e);
        send(1'b1, 1'b0, x);
        idle(5);
        chk3("R9 go ignored in lap", s - 1 - e);
        send(1'b0, 1'b1, u);
        run_until(e, 400);
        send(1'b1, 1'b0, p);
        idle(1);
        chk3("R7 counted during lap", p - e);
        t_clear();
    endtask

    task automatic t_both_running;
        int e, x, p;
        send(1'b1, 1'b0, e);
        run_until(e, 30);
        send(1'b1, 1'b1, x);
        run_until(e, 70);
        send(1'b1, 1'b0, p);
        idle(1);
        chk3("R10 both ignored in run", p - e);
        t_clear();
    endtask

    task automatic t_wrap;
        int e, p, r, q;
        send(1'b1, 1'b0, e);
        run_until(e, 59999);
        send(1'b1, 1'b0, p);
        idle(1);
        chk3("R1 maximum shown", p - e);
        send(1'b1, 1'b0, r);
        send(1'b1, 1'b0, q);
        idle(1);
        chk3("R2 R1 carry past maximum", (p - e) + (q - r));
        chk("R1 wrap to zero", sh_w, 24'h000000);
        chk("R2 minute tens carry", sh_i, 24'h100000);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_pause_resume();
        t_clear();
        t_split();
        t_both_running();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule